// File: doc/BRIEF.md
# Instruction fetch frontend

This block holds the program counter of a 32-bit in-order core and keeps the instruction stream moving. It issues fetch commands on a valid/ready command bus, takes the in-order responses at least one cycle later, and hands each fetched word to decode with its address on a valid/ready output. Responses have no ready signal. The block therefore never has more commands in flight plus words buffered than it has space for. With that credit limit it runs at one word per cycle when the bus has a fixed latency of `BUS_LAT` cycles.

Later pipeline stages redirect the stream through a bank of jump inputs, one per stage. A jump flushes every buffered word, turns every command still in flight into a stale one whose response is dropped on arrival, and restarts fetching at the target. One parameter chooses how the redirect reaches the bus. In immediate mode the target is placed on the command address in the same cycle. In relaxed mode the target is first registered, which costs one cycle. A second parameter registers the command-valid signal. A third adds an output register in front of decode. A response flagged as a bus error is passed on as a fault bit beside the word.

Top module: `ifetch_frontend`

## Requirements
- R1: In the first cycle after reset release, `cmd_addr` equals `RESET_VEC`, `cmd_valid` is high and `out_valid` is low.
- R2: When a command is accepted (`cmd_valid && cmd_ready`) in a cycle with no jump, the next accepted command, with no jump in between, has an address exactly 4 higher.
- R3: When several bits of `jmp_valid` are high together, the target of the highest index wins. Index 0 is the earliest stage. Target i occupies bits `[32*i +: 32]` of `jmp_target`.
- R4: In immediate mode (`RELAXED_PC=0`), `cmd_addr` equals the winning jump target in the same cycle that the jump is raised.
- R5: In relaxed mode (`RELAXED_PC=1`), `cmd_addr` equals the winning target in the cycle after the jump is raised.
- R6: `out_valid` is low in a cycle with a jump. After a jump, the first word delivered has `out_pc` equal to the target, and no word from the old path is delivered.
- R7: Delivered words come in program order. Each has `out_pc` one step of 4 above the previous word, and `out_instr` equal to the data the bus returned for that address.
- R8: Commands in flight plus words buffered never exceed `BUS_LAT+2`. While decode holds `out_ready` low, `cmd_valid` falls once that space is used, and no word is lost when decode resumes.
- R9: With `out_ready` high, no jumps and a bus of fixed latency `BUS_LAT`, one word is delivered in every cycle once the stream is running.
- R10: With `CATCH_FAULT=1`, `out_fault` is high exactly for the words whose response had `rsp_err` high.
- R11: The first word after reset appears on the output `BUS_LAT+1+INJECTOR` cycles after reset release, counting the release cycle as cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| jmp_valid | input | N_JUMP | Jump request per stage; a higher index is a later stage |
| jmp_target | input | N_JUMP*ADDR_W | Packed jump targets, one per stage |
| cmd_valid | output | 1 | Fetch command valid |
| cmd_ready | input | 1 | Bus accepts the command |
| cmd_addr | output | ADDR_W | Fetch address |
| rsp_valid | input | 1 | Fetch response valid, in command order |
| rsp_data | input | INSTR_W | Fetched word |
| rsp_err | input | 1 | Response carries a bus error |
| out_valid | output | 1 | Word available to decode |
| out_ready | input | 1 | Decode accepts the word |
| out_pc | output | ADDR_W | Address of the delivered word |
| out_instr | output | INSTR_W | Delivered word |
| out_fault | output | 1 | Access fault for the delivered word |

## Verification
The bench builds two copies of the block and drives the same jumps and decode stalls into both. The first copy uses immediate redirect, a combinational command-valid, a bus latency of 2 and no output register. It covers the same-cycle redirect and the case with the most commands in flight. The second copy uses relaxed redirect, a registered command-valid, a bus latency of 1 and the output register. It covers the one-cycle redirect penalty and stale commands issued in the jump cycle. A jump raised while decode is stalled and the buffer is full exercises the dropping of stale responses in both copies.

// File: rtl/ifetch_frontend.sv
module ifetch_frontend #(
  parameter int ADDR_W = 32,
  parameter int INSTR_W = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = 32'h8000_0000,
  parameter int N_JUMP = 3,
  parameter bit RELAXED_PC = 1'b0,
  parameter bit REG_CMD_VALID = 1'b0,
  parameter int BUS_LAT = 1,
  parameter bit INJECTOR = 1'b1,
  parameter bit CATCH_FAULT = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_JUMP-1:0]          jmp_valid,
  input  logic [N_JUMP*ADDR_W-1:0]   jmp_target,
  output logic                       cmd_valid,
  input  logic                       cmd_ready,
  output logic [ADDR_W-1:0]          cmd_addr,
  input  logic                       rsp_valid,
  input  logic [INSTR_W-1:0]         rsp_data,
  input  logic                       rsp_err,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [ADDR_W-1:0]          out_pc,
  output logic [INSTR_W-1:0]         out_instr,
  output logic                       out_fault
);
  localparam int DEPTH = BUS_LAT + 2;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);

  logic [ADDR_W-1:0] pc, rsp_pc, jump_tgt, pc_n;
  logic [CW-1:0] out_cnt, drop_cnt, fifo_cnt, out_cnt_n, drop_cnt_n, fifo_cnt_n;
  logic [PW-1:0] wr, rd;
  logic jump_any, cmd_fire, rsp_keep, take, pop, nonempty, stale_now, cmd_vq;

  logic [ADDR_W-1:0]  f_pc  [DEPTH];
  logic [INSTR_W-1:0] f_ins [DEPTH];
  logic               f_err [DEPTH];

  always_comb begin
    jump_any = 1'b0;
    jump_tgt = pc;
    for (int i = 0; i < N_JUMP; i++)
      if (jmp_valid[i]) begin
        jump_any = 1'b1;
        jump_tgt = jmp_target[i*ADDR_W +: ADDR_W];
      end
  end

  assign cmd_valid = REG_CMD_VALID ? cmd_vq : ({1'b0, out_cnt} + {1'b0, fifo_cnt} < (CW+1)'(DEPTH));
  assign cmd_addr  = (!RELAXED_PC && jump_any) ? jump_tgt : pc;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign stale_now = RELAXED_PC && cmd_fire;
  assign nonempty  = fifo_cnt != '0;
  assign rsp_keep  = rsp_valid && !jump_any && drop_cnt == '0;
  assign pop       = nonempty && take && !jump_any;

  assign out_cnt_n  = out_cnt + CW'(cmd_fire) - CW'(rsp_valid);
  assign drop_cnt_n = jump_any ? out_cnt - CW'(rsp_valid) + CW'(stale_now)
                               : drop_cnt - CW'(rsp_valid && drop_cnt != '0);
  assign fifo_cnt_n = jump_any ? '0 : fifo_cnt + CW'(rsp_keep) - CW'(pop);
  assign pc_n = (RELAXED_PC && jump_any) ? jump_tgt
                                         : cmd_addr + (cmd_fire ? ADDR_W'(4) : '0);

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pc       <= RESET_VEC;
      rsp_pc   <= RESET_VEC;
      out_cnt  <= '0;
      drop_cnt <= '0;
      fifo_cnt <= '0;
      wr       <= '0;
      rd       <= '0;
      cmd_vq   <= 1'b1;
    end else begin
      pc       <= pc_n;
      out_cnt  <= out_cnt_n;
      drop_cnt <= drop_cnt_n;
      fifo_cnt <= fifo_cnt_n;
      cmd_vq   <= ({1'b0, out_cnt_n} + {1'b0, fifo_cnt_n} < (CW+1)'(DEPTH));
      if (jump_any) begin
        rsp_pc <= jump_tgt;
        wr     <= '0;
        rd     <= '0;
      end else begin
        if (rsp_keep) begin
          rsp_pc <= rsp_pc + ADDR_W'(4);
          wr     <= nxt(wr);
        end
        if (pop) rd <= nxt(rd);
      end
    end

  always_ff @(posedge clk)
    if (rsp_keep) begin
      f_pc[wr]  <= rsp_pc;
      f_ins[wr] <= rsp_data;
      f_err[wr] <= rsp_err;
    end

  if (INJECTOR) begin : g_inj
    logic iv, ie;
    logic [ADDR_W-1:0] ip;
    logic [INSTR_W-1:0] iw;
    assign take = !iv || out_ready;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) iv <= 1'b0;
      else if (jump_any) iv <= 1'b0;
      else if (take) iv <= nonempty;
    always_ff @(posedge clk)
      if (pop) begin
        ip <= f_pc[rd];
        iw <= f_ins[rd];
        ie <= f_err[rd];
      end
    assign out_valid = iv && !jump_any;
    assign out_pc    = ip;
    assign out_instr = iw;
    assign out_fault = CATCH_FAULT && ie;
  end else begin : g_direct
    assign take      = out_ready;
    assign out_valid = nonempty && !jump_any;
    assign out_pc    = f_pc[rd];
    assign out_instr = f_ins[rd];
    assign out_fault = CATCH_FAULT && f_err[rd];
  end

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, out_cnt} + {1'b0, fifo_cnt}) <= (CW+1)'(DEPTH));

  a_r6_stale_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    drop_cnt <= out_cnt);

  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && !jump_any) |=> (jump_any || cmd_addr == $past(cmd_addr) + ADDR_W'(4)));

  a_r3_last_stage_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!RELAXED_PC && jmp_valid[N_JUMP-1]) |-> cmd_addr == jmp_target[(N_JUMP-1)*ADDR_W +: ADDR_W]);

  a_r5_relaxed_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (RELAXED_PC && jump_any) |=> cmd_addr == $past(jump_tgt));
endmodule

// File: tb/test_ifetch_frontend.sv
`timescale 1ns/1ps
module fetch_mem_model #(
  parameter int LAT = 1,
  parameter logic [31:0] FAULT_ADDR = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_fire,
  input  logic [31:0] cmd_addr,
  output logic        rsp_valid,
  output logic [31:0] rsp_data,
  output logic        rsp_err
);
  logic        lv [LAT];
  logic [31:0] la [LAT];
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int k = 0; k < LAT; k++) begin lv[k] <= 1'b0; la[k] <= '0; end
    end else begin
      lv[0] <= cmd_fire;
      la[0] <= cmd_addr;
      for (int k = 1; k < LAT; k++) begin lv[k] <= lv[k-1]; la[k] <= la[k-1]; end
    end
  assign rsp_valid = lv[LAT-1];
  assign rsp_data  = {la[LAT-1][15:0], la[LAT-1][31:16]} ^ 32'h5A5A_0F0F;
  assign rsp_err   = la[LAT-1] == FAULT_ADDR;
endmodule

module test_ifetch_frontend;
  localparam logic [31:0] RV = 32'h0000_1000;
  localparam logic [31:0] FAULT_ADDR = 32'h0000_1010;
  localparam int LAT_A = 2, LAT_B = 1;

  logic clk = 1'b0, rst_n = 1'b0, out_ready = 1'b1, cmd_ready = 1'b1;
  logic [2:0] jmp_valid = '0;
  logic [95:0] jmp_target = '0;
  always #2 clk = ~clk;

  logic a_cv, a_rv, a_re, a_ov, a_of, b_cv, b_rv, b_re, b_ov, b_of;
  logic [31:0] a_ca, a_rd, a_op, a_oi, b_ca, b_rd, b_op, b_oi;

  ifetch_frontend #(.RESET_VEC(RV), .RELAXED_PC(1'b0), .REG_CMD_VALID(1'b0),
                    .BUS_LAT(LAT_A), .INJECTOR(1'b0)) i_ifetch_frontend (
    .clk(clk), .rst_n(rst_n), .jmp_valid(jmp_valid), .jmp_target(jmp_target),
    .cmd_valid(a_cv), .cmd_ready(cmd_ready), .cmd_addr(a_ca),
    .rsp_valid(a_rv), .rsp_data(a_rd), .rsp_err(a_re),
    .out_valid(a_ov), .out_ready(out_ready), .out_pc(a_op), .out_instr(a_oi), .out_fault(a_of));
  fetch_mem_model #(.LAT(LAT_A), .FAULT_ADDR(FAULT_ADDR)) i_mem_a (
    .clk(clk), .rst_n(rst_n), .cmd_fire(a_cv && cmd_ready), .cmd_addr(a_ca),
    .rsp_valid(a_rv), .rsp_data(a_rd), .rsp_err(a_re));

  ifetch_frontend #(.RESET_VEC(RV), .RELAXED_PC(1'b1), .REG_CMD_VALID(1'b1),
                    .BUS_LAT(LAT_B), .INJECTOR(1'b1)) i_ifetch_frontend_rlx (
    .clk(clk), .rst_n(rst_n), .jmp_valid(jmp_valid), .jmp_target(jmp_target),
    .cmd_valid(b_cv), .cmd_ready(cmd_ready), .cmd_addr(b_ca),
    .rsp_valid(b_rv), .rsp_data(b_rd), .rsp_err(b_re),
    .out_valid(b_ov), .out_ready(out_ready), .out_pc(b_op), .out_instr(b_oi), .out_fault(b_of));
  fetch_mem_model #(.LAT(LAT_B), .FAULT_ADDR(FAULT_ADDR)) i_mem_b (
    .clk(clk), .rst_n(rst_n), .cmd_fire(b_cv && cmd_ready), .cmd_addr(b_ca),
    .rsp_valid(b_rv), .rsp_data(b_rd), .rsp_err(b_re));

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] exp_pc [2], prev_addr [2], first_pc [2];
  int outs [2], first_cyc [2], fault_seen [2];
  bit have [2], post_jump [2];

  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic mon(input int id, input logic ov, input logic [31:0] opc,
                     input logic [31:0] oins, input logic ofl, input logic cv,
                     input logic [31:0] ca);
    if (ov && out_ready) begin
      if (first_cyc[id] < 0) first_cyc[id] = cyc;
      chk(opc == exp_pc[id], "R7", "out_pc", opc, exp_pc[id]);
      chk(oins == memf(opc), "R7", "out_instr", oins, memf(opc));
      chk(ofl == (opc == FAULT_ADDR), "R10", "out_fault", 32'(ofl), 32'(opc == FAULT_ADDR));
      if (ofl) fault_seen[id]++;
      if (post_jump[id]) begin first_pc[id] = opc; post_jump[id] = 1'b0; end
      exp_pc[id] = exp_pc[id] + 4;
      outs[id]++;
    end
    if (cv && cmd_ready) begin
      if (have[id] && jmp_valid == '0)
        chk(ca == prev_addr[id] + 4, "R2", "cmd_addr step", ca, prev_addr[id] + 4);
      prev_addr[id] = ca;
      have[id] = 1'b1;
    end
    if (jmp_valid != '0) have[id] = 1'b0;
  endtask

  always @(negedge clk)
    if (rst_n) begin
      mon(0, a_ov, a_op, a_oi, a_of, a_cv, a_ca);
      mon(1, b_ov, b_op, b_oi, b_of, b_cv, b_ca);
    end

  task automatic set_jump(input logic [2:0] v, input logic [31:0] tgt);
    jmp_valid = v;
    for (int i = 0; i < 2; i++) begin exp_pc[i] = tgt; post_jump[i] = 1'b1; end
  endtask

  task automatic t_reset;
    for (int i = 0; i < 2; i++) begin
      exp_pc[i] = RV; outs[i] = 0; first_cyc[i] = -1; fault_seen[i] = 0;
      have[i] = 1'b0; post_jump[i] = 1'b0; first_pc[i] = '0;
    end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(a_ca == RV, "R1", "A cmd_addr", a_ca, RV);
    chk(b_ca == RV, "R1", "B cmd_addr", b_ca, RV);
    chk(a_cv && b_cv, "R1", "cmd_valid", {a_cv, b_cv}, 32'h3);
    chk(!a_ov && !b_ov, "R1", "out_valid", {a_ov, b_ov}, 32'h0);
  endtask

  task automatic t_stream;
    int n0, n1;
    repeat (10) @(posedge clk);
    chk(first_cyc[0] == LAT_A + 1, "R11", "A first output cycle", first_cyc[0], LAT_A + 1);
    chk(first_cyc[1] == LAT_B + 2, "R11", "B first output cycle", first_cyc[1], LAT_B + 2);
    n0 = outs[0]; n1 = outs[1];
    repeat (16) @(posedge clk);
    chk(outs[0] - n0 == 16, "R9", "A words in 16 cycles", outs[0] - n0, 16);
    chk(outs[1] - n1 == 16, "R9", "B words in 16 cycles", outs[1] - n1, 16);
    chk(fault_seen[0] == 1, "R10", "A faults seen", fault_seen[0], 1);
    chk(fault_seen[1] == 1, "R10", "B faults seen", fault_seen[1], 1);
  endtask

  task automatic t_jump_priority;
    @(posedge clk); #1;
    jmp_target = {32'h0000_3000, 32'h0000_2000, 32'h0000_0100};
    set_jump(3'b101, 32'h0000_3000);
    @(negedge clk);
    chk(a_ca == 32'h3000, "R4", "A cmd_addr in jump cycle (R3 priority)", a_ca, 32'h3000);
    chk(!a_ov && !b_ov, "R6", "out_valid in jump cycle", {a_ov, b_ov}, 32'h0);
    @(posedge clk); #1 jmp_valid = '0;
    @(negedge clk);
    chk(b_ca == 32'h3000, "R5", "B cmd_addr after jump (R3 priority)", b_ca, 32'h3000);
    repeat (10) @(posedge clk);
    chk(first_pc[0] == 32'h3000, "R6", "A first pc after jump", first_pc[0], 32'h3000);
    chk(first_pc[1] == 32'h3000, "R6", "B first pc after jump", first_pc[1], 32'h3000);
  endtask

  task automatic t_stall_then_jump;
    int n0, n1;
    @(posedge clk); #1 out_ready = 1'b0;
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk(!a_cv, "R8", "A cmd_valid while decode stalled", a_cv, 0);
    chk(!b_cv, "R8", "B cmd_valid while decode stalled", b_cv, 0);
    @(posedge clk); #1;
    jmp_target = {32'h0000_0700, 32'h0000_4000, 32'h0000_0500};
    set_jump(3'b010, 32'h0000_4000);
    @(posedge clk); #1 jmp_valid = '0;
    repeat (3) @(posedge clk);
    #1 out_ready = 1'b1;
    repeat (12) @(posedge clk);
    chk(first_pc[0] == 32'h4000, "R6", "A first pc after stalled jump", first_pc[0], 32'h4000);
    chk(first_pc[1] == 32'h4000, "R6", "B first pc after stalled jump", first_pc[1], 32'h4000);
    @(posedge clk); #1 out_ready = 1'b0;
    repeat (9) @(posedge clk);
    #1 out_ready = 1'b1;
    n0 = outs[0]; n1 = outs[1];
    repeat (12) @(posedge clk);
    chk(outs[0] - n0 >= 10, "R8", "A resumes after stall", outs[0] - n0, 10);
    chk(outs[1] - n1 >= 10, "R8", "B resumes after stall", outs[1] - n1, 10);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_stream();
    t_jump_priority();
    t_stall_then_jump();
    repeat (4) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule